// File: doc/BRIEF.md
# Burst Load/Store Timing Unit

This block sits beside a small processor core and carries out byte-counted burst transfers between a window of register-file byte lanes and a memory organised in 32-bit words. It stalls the core for a number of cycles that can be predicted exactly. That count depends only on how many 32-bit words the burst touches, plus any cycles that the environment itself withholds.

Loads read a local memory through a request/grant port. The read data comes back one cycle after each grant and is written back into the register window through per-byte-lane write enables. Stores are posted. Each touched word is pushed into an internal write buffer together with byte strobes, and the core is released as soon as the last word sits in the buffer. The buffer drains on its own through a valid/ready write port.

Byte i of a burst starting at byte address A and register lane S belongs to memory byte A+i and to register lane (S+i) mod 64. Bytes are ordered little-endian inside each word.

Top module: `burst_lsu`

## Requirements
- R1: After reset, stall, mem_req and wr_valid are low and ld_we is all zero.
- R2: A command is taken only in a cycle with cmd_valid high and stall low. Its length must be 1 to 64 bytes. While stall is high, cmd_valid and the command fields have no effect.
- R3: Let W = ((A mod 4) + len − 1) / 4 + 1 be the number of 32-bit words a burst touches. When the write buffer never fills, a store holds stall high for exactly W cycles after the acceptance cycle. For example, a 2-byte store at offset 0 or 2 costs 1 cycle, and a 2-byte store at offset 3 costs 2 cycles.
- R4: Stores are posted. A store that fits into free buffer space finishes its W stall cycles even while wr_ready stays low. Buffered words later leave on the write port in order, and they hold steady while wr_ready is low.
- R5: Each store word k, for k = 0 to W−1, appears on the write port with word address A/4 + k. Strobe bit j is set exactly when byte 4·(A/4+k)+j lies inside [A, A+len). Data byte j carries register lane (S + 4k + j − A mod 4) mod 64. Unselected bytes have their strobe clear.
- R6: When the write buffer (4 entries) is full, the store waits without pushing until an entry frees up. The wait adds to the stall, and no word is lost or duplicated.
- R7: With mem_gnt held high, a load holds stall high for exactly W + 2 cycles after the acceptance cycle. A 16-byte aligned load therefore stalls 6 cycles, and a 16-byte load at offset 1 stalls 7 cycles.
- R8: A load writes exactly len register lanes. Lane (S+i) mod 64 receives byte (A+i) mod 4 of memory word (A+i)/4. The first write-back comes in the third stall cycle, and ld_we is never set outside stall.
- R9: mem_req keeps mem_addr steady while mem_gnt is low. mem_rdata is taken one cycle after a granted request. Every cycle in which mem_req is high and mem_gnt is low adds exactly one stall cycle to a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_store | input | 1 | 1 = store, 0 = load |
| cmd_addr | input | 32 | Starting byte address |
| cmd_len | input | 7 | Byte count, 1 to 64 |
| cmd_lane | input | 6 | First register-window byte lane |
| cmd_wdata | input | 512 | Register-window bytes for stores (lane L at bits 8L+7:8L) |
| stall | output | 1 | Core stall, high for the cost of the running command |
| ld_we | output | 64 | Per-byte-lane write enable for load write-back |
| ld_data | output | 512 | Load write-back data, lane L at bits 8L+7:8L |
| mem_req | output | 1 | Local memory read request |
| mem_addr | output | 30 | Word address of the read request |
| mem_gnt | input | 1 | Read grant; low while the memory is taken by another master |
| mem_rdata | input | 32 | Read word, valid the cycle after a grant |
| wr_valid | output | 1 | Posted write buffer has a word to send |
| wr_ready | input | 1 | Downstream takes the word |
| wr_addr | output | 30 | Word address of the posted write |
| wr_data | output | 32 | Posted write data |
| wr_strb | output | 4 | Byte strobes of the posted write |

## Verification
The bench counts the cycles in which stall is high, starting from the first falling edge after the acceptance edge. A store with an always-ready write port must count exactly W, and a load must count W + 2 plus the number of falling edges on which mem_req was high with mem_gnt low. Load write-backs are captured on the falling edges inside that window, and the first one must fall on stall cycle 3. The bench collects posted writes on every falling edge at which valid and ready are both high, and compares them with the expected words only after the buffer has drained. In that way no check depends on when a word leaves the buffer.

// File: rtl/blsu_pkg.sv
package blsu_pkg;

   // True when burst offset off lies inside a burst of len bytes.
   function automatic bit in_burst(input int off, input int len);
      return (off >= 0) && (off < len);
   endfunction

   // Number of 32-bit words touched by a burst starting at byte offset a.
   function automatic int words_touched(input int a, input int len);
      return ((a + len - 1) / 4) + 1;
   endfunction

endpackage

// File: rtl/blsu_wbuf.sv
module blsu_wbuf #(
   parameter int EW    = 66,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [EW-1:0] din,
   input  logic          pop,
   output logic [EW-1:0] dout,
   output logic          full,
   output logic          empty
);

   logic [EW-1:0] slot_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q;
   logic [PW:0]   cnt_q;

   initial begin
      assert (DEPTH >= 2 && (1 << PW) == DEPTH)
         else $error("blsu_wbuf: DEPTH must be a power of two of at least 2");
   end

   always_ff @(posedge clk) begin
      if (push) slot_q[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + 1'b1;
         if (pop)  rp_q <= rp_q + 1'b1;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = slot_q[rp_q];
   assign full  = (cnt_q == (PW+1)'(DEPTH));
   assign empty = (cnt_q == '0);

   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= (PW+1)'(DEPTH));
   assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   assert_pop_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/blsu_gather.sv
module blsu_gather #(
   parameter int WIN  = 64,
   parameter int LW   = 6,
   parameter int LENW = 7,
   parameter int IDXW = 5
) (
   input  logic [1:0]       a,
   input  logic [IDXW-1:0]  idx,
   input  logic [LENW-1:0]  len,
   input  logic [LW-1:0]    lane,
   input  logic [WIN*8-1:0] win,
   output logic [3:0]       strb,
   output logic [31:0]      word
);

   for (genvar j = 0; j < 4; j++) begin : g_byte
      int          off;
      logic        hit;
      logic [LW-1:0] tgt;
      assign off  = int'(idx) * 4 + j - int'(a);
      assign hit  = blsu_pkg::in_burst(off, int'(len));
      assign tgt  = lane + LW'(off);
      assign strb[j]        = hit;
      assign word[8*j +: 8] = hit ? win[{tgt, 3'b000} +: 8] : 8'h00;
   end

endmodule

// File: rtl/blsu_scatter.sv
module blsu_scatter #(
   parameter int WIN  = 64,
   parameter int LW   = 6,
   parameter int LENW = 7,
   parameter int IDXW = 5
) (
   input  logic [1:0]       a,
   input  logic [IDXW-1:0]  idx,
   input  logic [LENW-1:0]  len,
   input  logic [LW-1:0]    lane,
   input  logic [31:0]      word,
   output logic [WIN-1:0]   we,
   output logic [WIN*8-1:0] data
);

   logic [3:0]    hit;
   logic [LW-1:0] tgt [4];

   for (genvar j = 0; j < 4; j++) begin : g_byte
      int off;
      assign off    = int'(idx) * 4 + j - int'(a);
      assign hit[j] = blsu_pkg::in_burst(off, int'(len));
      assign tgt[j] = lane + LW'(off);
   end

   always_comb begin
      we   = '0;
      data = '0;
      for (int l = 0; l < WIN; l++) begin
         for (int j = 0; j < 4; j++) begin
            if (hit[j] && tgt[j] == LW'(l)) begin
               we[l]          = 1'b1;
               data[8*l +: 8] = word[8*j +: 8];
            end
         end
      end
   end

endmodule

// File: rtl/burst_lsu.sv
module burst_lsu #(
   parameter int AW        = 32,
   parameter int WIN_BYTES = 64,
   parameter int MAX_LEN   = 64,
   parameter int WB_DEPTH  = 4,
   localparam int LW   = $clog2(WIN_BYTES),
   localparam int LENW = $clog2(MAX_LEN + 1),
   localparam int MAXW = (MAX_LEN + 6) / 4,
   localparam int IDXW = $clog2(MAXW + 1),
   localparam int WAW  = AW - 2,
   localparam int EW   = WAW + 36
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cmd_valid,
   input  logic                 cmd_store,
   input  logic [AW-1:0]        cmd_addr,
   input  logic [LENW-1:0]      cmd_len,
   input  logic [LW-1:0]        cmd_lane,
   input  logic [WIN_BYTES*8-1:0] cmd_wdata,
   output logic                 stall,
   output logic [WIN_BYTES-1:0] ld_we,
   output logic [WIN_BYTES*8-1:0] ld_data,
   output logic                 mem_req,
   output logic [WAW-1:0]       mem_addr,
   input  logic                 mem_gnt,
   input  logic [31:0]          mem_rdata,
   output logic                 wr_valid,
   input  logic                 wr_ready,
   output logic [WAW-1:0]       wr_addr,
   output logic [31:0]          wr_data,
   output logic [3:0]           wr_strb
);

   initial begin
      assert ((1 << LW) == WIN_BYTES && WIN_BYTES >= 4)
         else $error("burst_lsu: WIN_BYTES must be a power of two of at least 4");
      assert (MAX_LEN >= 1 && MAX_LEN <= WIN_BYTES)
         else $error("burst_lsu: MAX_LEN must lie in 1..WIN_BYTES");
      assert (AW > 2) else $error("burst_lsu: AW too small");
   end

   // command state
   logic                   busy_q, st_q;
   logic [1:0]             a_q;
   logic [WAW-1:0]         wbase_q;
   logic [LENW-1:0]        len_q;
   logic [LW-1:0]          lane_q;
   logic [IDXW-1:0]        nw_q, idx_q;
   logic [WIN_BYTES*8-1:0] wdat_q;

   // load pipeline
   logic                   rsp_v_q, rsp_last_q, wb_last_q;
   logic [IDXW-1:0]        rsp_idx_q;
   logic [WIN_BYTES-1:0]   ld_we_q;
   logic [WIN_BYTES*8-1:0] ld_data_q;

   logic                   accept, more, last_beat, push, fire, done;
   logic                   wb_full, wb_empty;
   logic [IDXW-1:0]        cmd_nw;
   logic [3:0]             g_strb;
   logic [31:0]            g_word;
   logic [WIN_BYTES-1:0]   s_we;
   logic [WIN_BYTES*8-1:0] s_data;
   logic [EW-1:0]          wb_din, wb_dout;

   assign accept    = cmd_valid && !busy_q;
   assign cmd_nw    = IDXW'(blsu_pkg::words_touched(int'(cmd_addr[1:0]), int'(cmd_len)));
   assign more      = idx_q < nw_q;
   assign last_beat = (idx_q == nw_q - 1'b1);
   assign push      = busy_q && st_q && more && !wb_full;
   assign mem_req   = busy_q && !st_q && more;
   assign fire      = mem_req && mem_gnt;
   assign done      = (push && last_beat) || wb_last_q;
   assign mem_addr  = wbase_q + WAW'(idx_q);
   assign stall     = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         st_q    <= 1'b0;
         a_q     <= '0;
         wbase_q <= '0;
         len_q   <= '0;
         lane_q  <= '0;
         nw_q    <= '0;
         idx_q   <= '0;
         wdat_q  <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         st_q    <= cmd_store;
         a_q     <= cmd_addr[1:0];
         wbase_q <= cmd_addr[AW-1:2];
         len_q   <= cmd_len;
         lane_q  <= cmd_lane;
         nw_q    <= cmd_nw;
         idx_q   <= '0;
         if (cmd_store) wdat_q <= cmd_wdata;
      end else begin
         if (push || fire) idx_q <= idx_q + 1'b1;
         if (done) busy_q <= 1'b0;
      end
   end

   // store side: gather one word per cycle into the posted buffer
   blsu_gather #(.WIN(WIN_BYTES), .LW(LW), .LENW(LENW), .IDXW(IDXW)) u_gather (
      .a(a_q), .idx(idx_q), .len(len_q), .lane(lane_q), .win(wdat_q),
      .strb(g_strb), .word(g_word)
   );

   assign wb_din = {mem_addr, g_strb, g_word};

   blsu_wbuf #(.EW(EW), .DEPTH(WB_DEPTH)) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(push), .din(wb_din),
      .pop(wr_valid && wr_ready), .dout(wb_dout),
      .full(wb_full), .empty(wb_empty)
   );

   assign wr_valid = !wb_empty;
   assign wr_addr  = wb_dout[EW-1 -: WAW];
   assign wr_strb  = wb_dout[35:32];
   assign wr_data  = wb_dout[31:0];

   // load side: request -> memory -> write-back
   blsu_scatter #(.WIN(WIN_BYTES), .LW(LW), .LENW(LENW), .IDXW(IDXW)) u_scatter (
      .a(a_q), .idx(rsp_idx_q), .len(len_q), .lane(lane_q), .word(mem_rdata),
      .we(s_we), .data(s_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_v_q    <= 1'b0;
         rsp_last_q <= 1'b0;
         rsp_idx_q  <= '0;
         wb_last_q  <= 1'b0;
         ld_we_q    <= '0;
         ld_data_q  <= '0;
      end else begin
         rsp_v_q    <= fire;
         rsp_last_q <= fire && last_beat;
         rsp_idx_q  <= idx_q;
         wb_last_q  <= rsp_last_q;
         ld_we_q    <= rsp_v_q ? s_we : '0;
         ld_data_q  <= s_data;
      end
   end

   assign ld_we   = ld_we_q;
   assign ld_data = ld_data_q;

   assert_len_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !stall) |-> (cmd_len >= 1 && int'(cmd_len) <= MAX_LEN));
   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
   assert_req_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> stall);
   assert_we_in_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (|ld_we) |-> stall);
   assert_strb_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_strb != 4'b0000));
   assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable({wr_addr, wr_strb, wr_data})));

endmodule

// File: tb/burst_lsu_test.sv
module burst_lsu_test;

   localparam int WIN = 64;
   localparam int WAW = 30;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_valid = 1'b0, cmd_store = 1'b0;
   logic [31:0]    cmd_addr = '0;
   logic [6:0]     cmd_len = 7'd1;
   logic [5:0]     cmd_lane = '0;
   logic [511:0]   cmd_wdata = '0;
   logic           stall;
   logic [63:0]    ld_we;
   logic [511:0]   ld_data;
   logic           mem_req;
   logic [WAW-1:0] mem_addr;
   logic           mem_gnt = 1'b1;
   logic [31:0]    mem_rdata = '0;
   logic           wr_valid;
   logic           wr_ready = 1'b1;
   logic [WAW-1:0] wr_addr;
   logic [31:0]    wr_data;
   logic [3:0]     wr_strb;

   always #5 clk = ~clk;

   burst_lsu uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_store(cmd_store),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_lane(cmd_lane), .cmd_wdata(cmd_wdata),
      .stall(stall), .ld_we(ld_we), .ld_data(ld_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_strb(wr_strb)
   );

   int n_tot = 0, n_bad = 0;
   bit finished = 1'b0;
   int gnt_mode = 0, rdy_mode = 0, rel_cnt = 0, gnt_wait = 0, rec_n = 0;
   logic [WAW-1:0] rec_a [128];
   logic [3:0]     rec_s [128];
   logic [31:0]    rec_d [128];
   logic [7:0]     img [WIN];
   bit             mark [WIN];
   int             we_total, first_we;

   function automatic logic [31:0] word_val(input logic [WAW-1:0] wa);
      logic [31:0] x;
      x = {2'b00, wa} * 32'h9E37_79B1;
      return x ^ {wa[13:0], wa[17:0]} ^ 32'h5A5A_0F0F;
   endfunction

   function automatic int n_words(input logic [31:0] addr, input int len);
      return ((int'(addr[1:0]) + len - 1) / 4) + 1;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // memory model: data one cycle after a granted request
   always @(posedge clk) begin
      if (mem_req && mem_gnt) mem_rdata <= word_val(mem_addr);
   end

   // environment: grant/ready pattern, grant-wait counter, write-port capture
   always @(negedge clk) begin
      mem_gnt = (gnt_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
      case (rdy_mode)
         0: wr_ready = 1'b1;
         1: wr_ready = (($urandom % 2) == 0);
         2: wr_ready = 1'b0;
         default: begin
            wr_ready = (rel_cnt == 0);
            if (rel_cnt > 0) rel_cnt--;
         end
      endcase
      if (mem_req && !mem_gnt) gnt_wait++;
      if (wr_valid && wr_ready && rec_n < 128) begin
         rec_a[rec_n] = wr_addr;
         rec_s[rec_n] = wr_strb;
         rec_d[rec_n] = wr_data;
         rec_n++;
      end
   end

   task automatic capture_we(input int cyc);
      for (int l = 0; l < WIN; l++) begin
         if (ld_we[l]) begin
            we_total++;
            mark[l] = 1'b1;
            img[l]  = ld_data[8*l +: 8];
            if (first_we < 0) first_we = cyc;
         end
      end
   endtask

   // issue one command, count stall cycles; poison drives another command during stall (R2)
   task automatic run_cmd(input bit st, input logic [31:0] addr, input int len, input int lane,
                          input logic [511:0] wd, input bit poison, output int stalls);
      @(negedge clk);
      while (stall) @(negedge clk);
      for (int l = 0; l < WIN; l++) begin img[l] = 8'h00; mark[l] = 1'b0; end
      we_total = 0; first_we = -1; gnt_wait = 0; stalls = 0;
      cmd_valid = 1'b1; cmd_store = st; cmd_addr = addr;
      cmd_len = 7'(len); cmd_lane = 6'(lane); cmd_wdata = wd;
      forever begin
         @(negedge clk);
         if (!stall) begin
            cmd_valid = 1'b0;
            capture_we(stalls + 1);
            break;
         end
         stalls++;
         capture_we(stalls);
         if (poison) begin
            cmd_valid = 1'b1; cmd_store = ~st; cmd_addr = addr + 32'h40;
            cmd_len = 7'd9; cmd_lane = 6'(lane + 5); cmd_wdata = ~wd;
         end else begin
            cmd_valid = 1'b0;
         end
      end
   endtask

   task automatic drain();
      rdy_mode = 0;
      for (int i = 0; i < 400 && wr_valid; i++) @(negedge clk);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic do_store(input logic [31:0] addr, input int len, input int lane,
                           input int mode, input bit exact, input bit poison,
                           input string treq, output int stalls);
      logic [511:0] wd;
      int w, nbad;
      for (int k = 0; k < 16; k++) wd[32*k +: 32] = $urandom;
      drain();
      rec_n = 0;
      rdy_mode = mode;
      run_cmd(1'b1, addr, len, lane, wd, poison, stalls);
      w = n_words(addr, len);
      if (exact) chk(stalls == w, treq, "store stall cycles", stalls, w);
      else       chk(stalls >= w, treq, "store stall at least W", stalls, w);
      drain();
      chk(rec_n == w, "R5", "posted write count", rec_n, w);
      nbad = 0;
      for (int k = 0; k < w && k < rec_n; k++) begin
         logic [3:0]  es;
         logic [31:0] ed;
         es = '0; ed = '0;
         for (int j = 0; j < 4; j++) begin
            int off;
            off = k * 4 + j - int'(addr[1:0]);
            if (off >= 0 && off < len) begin
               es[j] = 1'b1;
               ed[8*j +: 8] = wd[8*((lane + off) % WIN) +: 8];
            end
         end
         if (rec_a[k] != addr[31:2] + WAW'(k) || rec_s[k] != es || rec_d[k] != ed) begin
            if (nbad == 0)
               $display("FAIL R5 write word %0d: actual=%h/%h/%h expected=%h/%h/%h", k,
                        rec_a[k], rec_s[k], rec_d[k], addr[31:2] + WAW'(k), es, ed);
            nbad++;
         end
      end
      n_tot++;
      if (nbad != 0) n_bad++;
   endtask

   task automatic do_load(input logic [31:0] addr, input int len, input int lane,
                          input int gmode, input bit poison, input string treq,
                          output int stalls);
      int w, nbad, nmark;
      gnt_mode = gmode;
      run_cmd(1'b0, addr, len, lane, '0, poison, stalls);
      gnt_mode = 0;
      w = n_words(addr, len);
      chk(stalls == w + 2 + gnt_wait, treq, "load stall cycles", stalls, w + 2 + gnt_wait);
      chk(we_total == len, "R8", "lanes written", we_total, len);
      nbad = 0; nmark = 0;
      for (int l = 0; l < WIN; l++) if (mark[l]) nmark++;
      for (int i = 0; i < len; i++) begin
         logic [31:0] ba;
         logic [7:0]  eb;
         int l;
         ba = addr + 32'(i);
         eb = word_val(ba[31:2])[8*ba[1:0] +: 8];
         l  = (lane + i) % WIN;
         if (!mark[l] || img[l] != eb) nbad++;
      end
      chk(nbad == 0, "R8", "lane data mismatches", nbad, 0);
      chk(nmark == len, "R8", "distinct lanes written", nmark, len);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_tot++; n_bad++;
         $display("FAIL R2 watchdog: actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

   initial begin
      int s;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(stall == 1'b0,   "R1", "stall after reset", stall, 0);
      chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
      chk(wr_valid == 1'b0,"R1", "wr_valid after reset", wr_valid, 0);
      chk(ld_we == '0,     "R1", "ld_we after reset", 64'(ld_we), 0);

      // R3: alignment cost of short stores
      do_store(32'h100, 2, 0, 0, 1'b1, 1'b0, "R3", s);
      do_store(32'h102, 2, 3, 0, 1'b1, 1'b0, "R3", s);
      do_store(32'h103, 2, 7, 0, 1'b1, 1'b0, "R3", s);
      chk(s == 2, "R3", "2-byte store at offset 3", s, 2);
      chk(rec_s[0] == 4'b1000 && rec_s[1] == 4'b0001, "R5", "strobes at offset 3",
          {rec_s[0], rec_s[1]}, 8'h81);
      do_store(32'h201, 64, 60, 0, 1'b1, 1'b0, "R3", s);
      chk(s == 17, "R3", "64-byte store at offset 1", s, 17);

      // R7: load timing, R8: write-back timing
      do_load(32'h400, 16, 0, 0, 1'b0, "R7", s);
      chk(s == 6, "R7", "16-byte aligned load", s, 6);
      chk(first_we == 3, "R8", "first write-back stall cycle", first_we, 3);
      do_load(32'h401, 16, 10, 0, 1'b0, "R7", s);
      chk(s == 7, "R7", "16-byte load at offset 1", s, 7);
      do_load(32'h7FF, 1, 63, 0, 1'b0, "R7", s);
      chk(s == 3, "R7", "single-byte load", s, 3);
      do_load(32'h502, 64, 33, 0, 1'b0, "R8", s);

      // R9: grant withheld
      do_load(32'h600, 64, 0, 1, 1'b0, "R9", s);
      chk(gnt_wait > 0, "R9", "grant-low cycles observed", gnt_wait, 1);

      // R4: posted store completes with write port blocked
      do_store(32'h800, 16, 4, 2, 1'b1, 1'b0, "R4", s);
      chk(s == 4, "R4", "posted store stall with wr_ready low", s, 4);

      // R6: buffer full holds the store
      rel_cnt = 24;
      do_store(32'h900, 32, 0, 3, 1'b0, 1'b0, "R6", s);
      chk(s >= 18 && s <= 40, "R6", "stall while buffer full", s, 24);

      // R2: commands during stall are ignored
      do_store(32'hA03, 20, 9, 0, 1'b1, 1'b1, "R2", s);
      do_load(32'hB01, 30, 17, 0, 1'b1, "R2", s);

      // constrained random mix
      for (int t = 0; t < 120; t++) begin
         logic [31:0] ad;
         int ln, lnn, md;
         ad  = $urandom & 32'h0000_FFFF;
         ln  = 1 + int'($urandom % 64);
         lnn = int'($urandom % 64);
         if ($urandom % 2) begin
            md = ($urandom % 2 == 0) ? 0 : 1;
            do_store(ad, ln, lnn, md, md == 0, 1'b0, "R3", s);
         end else begin
            do_load(ad, ln, lnn, int'($urandom % 2), 1'b0, "R9", s);
         end
      end

      drain();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   end

endmodule